// File: doc/BRIEF.md
# DMA sound instruction sequencer

This block is a single sound DMA channel. Once enabled, it reads 16-bit command words from memory through a request/grant read port, one word at a time. It executes each word before it fetches the next. The commands write a register of an attached sound generator, wait for a number of prescaler ticks, open and close a counted loop, raise an interrupt request, or stop the channel.

The CPU side has set and clear pulses for the channel enable, and it can load the source address while the channel is halted. A stop command clears the enable. It leaves the address on the word after the stop, so setting the enable again continues the stream from there.

Command word layout: bits 15..12 hold the opcode. The opcodes are 0 register write (register index in 11..8, value in 7..0), 1 wait (tick count in 11..0), 2 loop start (count in 11..0), 3 loop end, 4 interrupt, 5 stop. Opcodes 6 to 15 do nothing.

Top module: `snd_dma_seq`

## Requirements
- R1: After reset the channel is disabled, `mem_req`, `reg_wr` and `irq_req` are low, and the address is 0.
- R2: While fetching, `mem_req` is high with `mem_addr` equal to the current address. Both stay unchanged until `mem_gnt`. The word on `mem_rdata` in the grant cycle is taken, and the address advances by one.
- R3: Opcode 0 produces a one-cycle `reg_wr` pulse with `reg_idx` = bits 11..8 and `reg_data` = bits 7..0. Writes appear in program order, and never in a cycle with `mem_req` high.
- R4: Opcode 1 with count N (bits 11..0) holds off the next fetch until N `tick` pulses have been seen. N = 0 causes no wait.
- R5: Opcode 2 with count N (bits 11..0) marks the next word as the loop start. Each opcode 3 branches back while the remaining count is nonzero and decrements it, so the body runs N+1 times. A count of zero falls through.
- R6: Opcode 4 sets `irq_req`. The flag stays high until an `irq_clr` pulse.
- R7: Opcode 5 clears `chan_en` and leaves `cur_addr` at the word after the stop. A later `en_set` resumes fetching there.
- R8: After `en_clr`, the channel finishes the fetch and instruction in progress, then starts no further fetch. `en_set` resumes from the held address, and no command is lost or repeated.
- R9: An `addr_ld` pulse while the channel is halted sets `cur_addr` to `addr_ld_val`.
- R10: Opcodes 6 to 15 produce no register write and no interrupt. Execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | 1 | CPU pulse: set channel enable |
| en_clr | input | 1 | CPU pulse: clear channel enable |
| addr_ld | input | 1 | CPU pulse: load source address |
| addr_ld_val | input | ADDR_W | Address to load |
| tick | input | 1 | Prescaler strobe for waits |
| irq_clr | input | 1 | CPU pulse: clear interrupt request |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read word address |
| mem_gnt | input | 1 | Grant; data valid this cycle |
| mem_rdata | input | 16 | Command word |
| reg_wr | output | 1 | Sound register write strobe |
| reg_idx | output | 4 | Sound register index |
| reg_data | output | 8 | Sound register value |
| irq_req | output | 1 | Interrupt request flag |
| chan_en | output | 1 | Channel enable state |
| cur_addr | output | ADDR_W | Current source address |

## Verification
The assertions assume that `mem_gnt` is high only while `mem_req` is high. They also assume that `addr_ld` is pulsed only while the channel is halted, because an address load during a fetch would otherwise move `mem_addr` under an open request. The bench's memory model derives its grant from the request itself, either at once or on every fourth cycle. Every address load waits until `chan_en` is low and the request line is idle.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned VAL_W  = 8;
  localparam int unsigned CNT_W  = 12;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD   = 4'd0,
    OP_WAIT   = 4'd1,
    OP_REPEAT = 4'd2,
    OP_LOOP   = 4'd3,
    OP_INT    = 4'd4,
    OP_STOP   = 4'd5
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/snd_dma_pause.sv
module snd_dma_pause #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/snd_dma_loop.sv
module snd_dma_loop #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic [CNT_W-1:0]  arm_cnt,
  input  logic              loop_op,
  output logic              take,
  output logic [ADDR_W-1:0] ret_addr
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] ret_q;
  logic              cnt_en;

  assign take     = (cnt_q != '0);
  assign ret_addr = ret_q;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (arm) begin
      cnt_d  = arm_cnt;
      cnt_en = 1'b1;
    end else if (loop_op && take) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ret_q <= '0;
    else if (arm) ret_q <= arm_addr;
  end
endmodule

// File: rtl/snd_dma_seq.sv
module snd_dma_seq
  import snd_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_ld_val,
  input  logic              tick,
  input  logic              irq_clr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              reg_wr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [VAL_W-1:0]  reg_data,
  output logic              irq_req,
  output logic              chan_en,
  output logic [ADDR_W-1:0] cur_addr
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] ir_q;
  logic              ir_we;
  logic              en_q, en_d;
  logic              irq_q, irq_d;
  opcode_e           op;
  logic [CNT_W-1:0]  arg;
  logic              tmr_load, tmr_expired;
  logic              loop_arm, loop_op, loop_take;
  logic [ADDR_W-1:0] loop_ret;
  logic              stop_hit, irq_set;
  logic              pause_busy;

  assign op         = opcode_e'(ir_q[WORD_W-1 -: OPC_W]);
  assign arg        = ir_q[CNT_W-1:0];
  assign ir_we      = (state_q == ST_FETCH) && mem_gnt;
  assign pause_busy = (state_q == ST_WAIT);

  snd_dma_pause #(.CNT_W(CNT_W)) u_pause (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (arg),
    .tick     (tick),
    .expired  (tmr_expired)
  );

  snd_dma_loop #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (loop_arm),
    .arm_addr (addr_q),
    .arm_cnt  (arg),
    .loop_op  (loop_op),
    .take     (loop_take),
    .ret_addr (loop_ret)
  );

  // sequencing and address next-state
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    tmr_load = 1'b0;
    loop_arm = 1'b0;
    loop_op  = 1'b0;
    stop_hit = 1'b0;
    irq_set  = 1'b0;
    reg_wr   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (en_q) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (mem_gnt) begin
          addr_d  = addr_q + 1'b1;
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        state_d = en_q ? ST_FETCH : ST_IDLE;
        case (op)
          OP_LOAD:   reg_wr = 1'b1;
          OP_WAIT: begin
            tmr_load = 1'b1;
            state_d  = ST_WAIT;
          end
          OP_REPEAT: loop_arm = 1'b1;
          OP_LOOP: begin
            loop_op = 1'b1;
            if (loop_take) addr_d = loop_ret;
          end
          OP_INT:    irq_set = 1'b1;
          OP_STOP: begin
            stop_hit = 1'b1;
            state_d  = ST_IDLE;
          end
          default: ;
        endcase
      end
      ST_WAIT: begin
        if (tmr_expired) state_d = en_q ? ST_FETCH : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (addr_ld) addr_d = addr_ld_val;
  end

  // enable and interrupt next-state
  always_comb begin
    en_d = en_q;
    if (en_set) en_d = 1'b1;
    if (en_clr || stop_hit) en_d = 1'b0;
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      en_q    <= en_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_we) ir_q <= mem_rdata;
  end

  assign mem_req  = (state_q == ST_FETCH);
  assign mem_addr = addr_q;
  assign reg_idx  = ir_q[IDX_W+VAL_W-1:VAL_W];
  assign reg_data = ir_q[VAL_W-1:0];
  assign irq_req  = irq_q;
  assign chan_en  = en_q;
  assign cur_addr = addr_q;
endmodule

// File: rtl/snd_dma_seq_chk.sv
module snd_dma_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              reg_wr,
  input logic              irq_req,
  input logic              irq_clr,
  input logic              chan_en,
  input logic              en_clr
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R3
  wr_not_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !mem_req);

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_clr) |=> irq_req);

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(chan_en) && !$past(en_clr)) |-> !mem_req);

  // R8
  fetch_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(chan_en));
endmodule

bind snd_dma_seq snd_dma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/snd_dma_seq_bench.sv
module snd_dma_seq_bench;
  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          en_set, en_clr, addr_ld, tick, irq_clr;
  logic [AW-1:0] addr_ld_val;
  logic          mem_req, mem_gnt;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_rdata;
  logic          reg_wr;
  logic [3:0]    reg_idx;
  logic [7:0]    reg_data;
  logic          irq_req, chan_en;
  logic [AW-1:0] cur_addr;

  logic [15:0] mem [0:255];
  logic [11:0] wlog [0:255];
  int          wr_n;
  int          total, bad;
  logic        stall_en;
  logic [1:0]  cyc;

  snd_dma_seq #(.ADDR_W(AW)) u_snd_dma_seq (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
    .addr_ld(addr_ld), .addr_ld_val(addr_ld_val), .tick(tick),
    .irq_clr(irq_clr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .reg_wr(reg_wr),
    .reg_idx(reg_idx), .reg_data(reg_data), .irq_req(irq_req),
    .chan_en(chan_en), .cur_addr(cur_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 2'd1;
  assign mem_gnt   = mem_req && (!stall_en || (cyc == 2'd3));
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      wlog[wr_n[7:0]] = {reg_idx, reg_data};
      wr_n = wr_n + 1;
    end
  end

  function automatic logic [15:0] w_ld(input logic [3:0] i, input logic [7:0] d);
    return {4'h0, i, d};
  endfunction
  function automatic logic [15:0] w_op(input logic [3:0] o, input logic [11:0] n);
    return {o, n};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_set();
    en_set = 1'b1; @(negedge clk); en_set = 1'b0;
  endtask

  task automatic start_at(input logic [AW-1:0] a);
    addr_ld_val = a; addr_ld = 1'b1; @(negedge clk); addr_ld = 1'b0;
    chk("R9 address load", int'(cur_addr), int'(a));
    pulse_set();
  endtask

  task automatic wait_halt();
    int n = 0;
    @(negedge clk);
    while ((chan_en || mem_req) && n < 3000) begin
      @(negedge clk); n++;
    end
    cycles(3);
    chk("R7 channel reaches stop", int'(chan_en), 0);
  endtask

  task automatic t_reset();
    chk("R1 enable after reset", int'(chan_en), 0);
    chk("R1 request after reset", int'(mem_req), 0);
    chk("R1 irq after reset", int'(irq_req), 0);
    chk("R1 write after reset", int'(reg_wr), 0);
    chk("R1 address after reset", int'(cur_addr), 0);
  endtask

  task automatic t_load_stop();
    int b = wr_n;
    mem[8'h10] = w_ld(4'h1, 8'hAA);
    mem[8'h11] = w_ld(4'h2, 8'h55);
    mem[8'h12] = w_ld(4'hF, 8'h01);
    mem[8'h13] = w_op(4'h5, 12'h0);
    start_at(16'h0010);
    wait_halt();
    chk("R3 write count", wr_n - b, 3);
    chk("R3 first write", int'(wlog[b]), 12'h1AA);
    chk("R3 second write", int'(wlog[b+1]), 12'h255);
    chk("R3 third write", int'(wlog[b+2]), 12'hF01);
    chk("R7 address after stop", int'(cur_addr), 16'h0014);
  endtask

  task automatic t_repeat();
    int b = wr_n;
    mem[8'h20] = w_op(4'h2, 12'd2);
    mem[8'h21] = w_ld(4'h3, 8'h11);
    mem[8'h22] = w_op(4'h3, 12'h0);
    mem[8'h23] = w_op(4'h2, 12'd0);
    mem[8'h24] = w_ld(4'h4, 8'h22);
    mem[8'h25] = w_op(4'h3, 12'h0);
    mem[8'h26] = 16'hE123;
    mem[8'h27] = 16'h6FFF;
    mem[8'h28] = w_op(4'h5, 12'h0);
    start_at(16'h0020);
    wait_halt();
    chk("R5 body N+1 plus once", wr_n - b, 4);
    chk("R5 loop body value", int'(wlog[b+2]), 12'h311);
    chk("R5 zero count falls through", int'(wlog[b+3]), 12'h422);
    chk("R10 unknown opcodes skipped", int'(cur_addr), 16'h0029);
    chk("R10 no irq from unknown", int'(irq_req), 0);
  endtask

  task automatic t_pause();
    int b = wr_n;
    mem[8'h30] = w_ld(4'h5, 8'h01);
    mem[8'h31] = w_op(4'h1, 12'd3);
    mem[8'h32] = w_ld(4'h5, 8'h02);
    mem[8'h33] = w_op(4'h1, 12'd0);
    mem[8'h34] = w_ld(4'h5, 8'h03);
    mem[8'h35] = w_op(4'h5, 12'h0);
    start_at(16'h0030);
    cycles(40);
    chk("R4 held without ticks", wr_n - b, 1);
    for (int i = 0; i < 2; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; cycles(3);
    end
    cycles(10);
    chk("R4 held after N-1 ticks", wr_n - b, 1);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    wait_halt();
    chk("R4 released after N ticks, zero wait free", wr_n - b, 3);
    chk("R4 final value", int'(wlog[b+2]), 12'h503);
  endtask

  task automatic t_irq();
    mem[8'h40] = w_op(4'h4, 12'h0);
    mem[8'h41] = w_op(4'h5, 12'h0);
    start_at(16'h0040);
    wait_halt();
    chk("R6 irq raised", int'(irq_req), 1);
    cycles(5);
    chk("R6 irq held", int'(irq_req), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R6 irq cleared", int'(irq_req), 0);
  endtask

  task automatic t_disable();
    int b = wr_n;
    int n1;
    for (int i = 0; i < 8; i++) mem[8'h50 + i] = w_ld(4'h6, 8'(i));
    mem[8'h58] = w_op(4'h5, 12'h0);
    stall_en = 1'b1;
    start_at(16'h0050);
    cycles(6);
    en_clr = 1'b1; @(negedge clk); en_clr = 1'b0;
    cycles(20);
    n1 = wr_n - b;
    chk("R8 halted early", int'(n1 < 8), 1);
    chk("R8 no request while halted", int'(mem_req), 0);
    cycles(20);
    chk("R8 no progress while halted", wr_n - b, n1);
    pulse_set();
    wait_halt();
    chk("R8 all writes after resume", wr_n - b, 8);
    for (int i = 0; i < 8; i++)
      chk("R2 stalled fetch order", int'(wlog[b+i]), 12'h600 + i);
    stall_en = 1'b0;
  endtask

  task automatic t_resume();
    int b = wr_n;
    mem[8'h60] = w_ld(4'h7, 8'h01);
    mem[8'h61] = w_op(4'h5, 12'h0);
    mem[8'h62] = w_ld(4'h7, 8'h02);
    mem[8'h63] = w_op(4'h5, 12'h0);
    start_at(16'h0060);
    wait_halt();
    chk("R7 first stop address", int'(cur_addr), 16'h0062);
    pulse_set();
    wait_halt();
    chk("R7 resumed after stop", wr_n - b, 2);
    chk("R7 resumed value", int'(wlog[b+1]), 12'h702);
    chk("R7 second stop address", int'(cur_addr), 16'h0064);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; wr_n = 0; cyc = 2'd0; stall_en = 1'b0;
    en_set = 0; en_clr = 0; addr_ld = 0; addr_ld_val = '0; tick = 0; irq_clr = 0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h5000;
    rst_n = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_load_stop();
    t_repeat();
    t_pause();
    t_irq();
    t_disable();
    t_resume();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule